// File: doc/BRIEF.md
# Interrupt and Hold-Wake Event Controller

This block gathers eight single-cycle event pulses from the surrounding peripherals and latches each one in an event flag. The sources are a divider overflow, two timer underflows, a port pin-change event, an external pin falling edge, a serial receive-done and a serial transmit-done. Two write-only masks act on the latched flags. The interrupt-enable mask turns a flag into a vectored interrupt request. The hold-enable mask turns the same flag into a hold-release cause.

When several requests are pending, the lowest flag index wins. The block presents that source's entry address to the core. When the core accepts the request, only that source's flag is cleared and interrupts are globally inhibited. They stay inhibited until software issues an enable command or rewrites the interrupt-enable mask. The hold-release causes are readable one nibble at a time. While any cause is pending, the core cannot enter hold. An interrupt taken during hold leaves hold for the service routine, and the return-from-interrupt strobe puts the block back into hold.

All command inputs are single-cycle strobes sampled on the rising clock edge. There is no streamed data path, so every pin is plain control or status. After reset, interrupts are globally enabled, but both masks are zero.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Flag positions are 0 divider overflow, 1 timer 0 underflow, 2 pin change, 3 reserved, 4 external falling edge, 5 serial receive done, 6 serial transmit done, 7 timer 1 underflow. A pulse on `evt_pulse_i[k]` sets flag k on the next edge and the flag stays set. Flag 3 always reads 0.
- R2: A `clr_evt_i` strobe clears every flag whose bit is 1 in `clr_mask_i` and leaves the others unchanged. A pulse arriving in the same cycle as a clear of that bit keeps the flag set.
- R3: `irq_req_o` is 1 exactly when interrupts are globally enabled and some flag is set together with its bit in the interrupt-enable mask. The lowest such index k is selected, and `irq_vec_o` = 4*(k+1), giving 004h, 008h, 00Ch, 014h, 018h, 01Ch and 020h.
- R4: `irq_ack_i` while `irq_req_o` is 1 clears only the selected flag and globally inhibits interrupts from the next cycle.
- R5: `gie_set_i` or any write of the interrupt-enable mask (`ien_wr_i`) re-enables interrupts globally. `gie_clr_i` inhibits them.
- R6: The cause vector equals flags AND hold-enable mask. `cause_nib_o` shows cause bits 3:0 when `cause_sel_i`=0 and bits 7:4 when it is 1. Clearing flags or writing a zero hold-enable value clears the matching cause bits.
- R7: `hold_req_i` puts the block in hold (`hold_o`=1 on the next edge) only while the cause vector is zero. A nonzero cause vector forces `hold_o` to 0 on the next edge.
- R8: A pending interrupt request during hold drops `hold_o` on the next edge. The next `reti_i` strobe, with no cause pending, sets `hold_o` again.
- R9: Reset clears all flags, both masks, the cause vector and the hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse_i | input | 8 | Event pulses, one per flag position |
| clr_evt_i | input | 1 | Clear-flags strobe |
| clr_mask_i | input | 8 | Flags to clear with `clr_evt_i` |
| ien_wr_i | input | 1 | Interrupt-enable mask write strobe |
| ien_data_i | input | 8 | Interrupt-enable mask value |
| hen_wr_i | input | 1 | Hold-enable mask write strobe |
| hen_data_i | input | 8 | Hold-enable mask value |
| gie_set_i | input | 1 | Global interrupt enable command |
| gie_clr_i | input | 1 | Global interrupt disable command |
| irq_ack_i | input | 1 | Core accepts the current request |
| hold_req_i | input | 1 | Core requests hold mode |
| reti_i | input | 1 | Return-from-interrupt strobe |
| cause_sel_i | input | 1 | Cause nibble select |
| evt_flags_o | output | 8 | Latched event flags |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | 11 | Entry address of the selected source |
| hold_o | output | 1 | Block is in hold |
| cause_nib_o | output | 4 | Selected hold-release cause nibble |

## Verification
The bound checker watches four things on every cycle: the reserved flag stays low, a pulse always wins over a same-cycle clear, an accepted request drops the request line, and a request never exists without a flag. It also checks that a nonzero cause or an interrupt during hold forces the block out of hold. Some behaviour only the bench scenarios can show. These are the exact vector chosen from every flag pattern, and gating by every interrupt mask. They also include the cause nibbles for every hold mask, and the full hold, wake, service and return sequence with hold re-entry.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int EVT_N     = 8;
  localparam int VEC_BITS  = 11;
  localparam int VEC_STEP  = 4;
  localparam int NIB_BITS  = 4;
  localparam logic [EVT_N-1:0] RSVD_BITS = 8'h08;
endpackage

// File: rtl/evtc_flag_bank.sv
module evtc_flag_bank #(
  parameter int N_EVT = evtc_pkg::EVT_N,
  parameter logic [N_EVT-1:0] RSVD = evtc_pkg::RSVD_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] pulse,
  input  logic             clr_en,
  input  logic [N_EVT-1:0] clr_mask,
  input  logic [N_EVT-1:0] grant,
  output logic [N_EVT-1:0] flags
);
  logic [N_EVT-1:0] flag_q;
  logic [N_EVT-1:0] kill;

  // flags removed this cycle: software mask plus the accepted source
  assign kill = (clr_en ? clr_mask : '0) | grant;

  // a new pulse outranks a same-cycle removal
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (pulse | (flag_q & ~kill)) & ~RSVD;
  end

  assign flags = flag_q;
endmodule

// File: rtl/evtc_arbiter.sv
module evtc_arbiter #(
  parameter int N_EVT    = evtc_pkg::EVT_N,
  parameter int VEC_W    = evtc_pkg::VEC_BITS,
  parameter int STEP     = evtc_pkg::VEC_STEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] flags,
  input  logic [N_EVT-1:0] ien,
  input  logic             en_cmd,
  input  logic             dis_cmd,
  input  logic             ack,
  output logic             req,
  output logic [VEC_W-1:0] vec,
  output logic [N_EVT-1:0] grant
);
  localparam int IDX_W = (N_EVT > 1) ? $clog2(N_EVT) : 1;

  logic             gie_q;
  logic [N_EVT-1:0] pend;
  logic [IDX_W-1:0] win;
  logic             accept;

  assign pend = flags & ien;

  // lowest index has the highest priority
  always_comb begin
    win = '0;
    for (int i = N_EVT - 1; i >= 0; i--) begin
      if (pend[i]) win = IDX_W'(i);
    end
  end

  assign req    = gie_q && (pend != '0);
  assign vec    = VEC_W'((32'(win) + 1) * STEP);
  assign accept = req && ack;
  assign grant  = accept ? (N_EVT'(1) << win) : '0;

  // enable commands win over acceptance and disable in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gie_q <= 1'b1;
    else if (en_cmd)            gie_q <= 1'b1;
    else if (accept || dis_cmd) gie_q <= 1'b0;
  end
endmodule

// File: rtl/evtc_hold_ctrl.sv
module evtc_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cause_any,
  input  logic irq_req,
  input  logic hold_req,
  input  logic reti,
  output logic hold
);
  logic hold_q;
  logic resume_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      resume_q <= 1'b0;
    end else if (cause_any) begin
      hold_q   <= 1'b0;
      resume_q <= 1'b0;
    end else if (hold_q && irq_req) begin
      hold_q   <= 1'b0;
      resume_q <= 1'b1;
    end else if (!hold_q && hold_req) begin
      hold_q   <= 1'b1;
    end else if (!hold_q && reti && resume_q) begin
      hold_q   <= 1'b1;
      resume_q <= 1'b0;
    end
  end

  assign hold = hold_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int N_EVT = evtc_pkg::EVT_N,
  parameter int VEC_W = evtc_pkg::VEC_BITS,
  parameter int STEP  = evtc_pkg::VEC_STEP,
  parameter int NIB   = evtc_pkg::NIB_BITS,
  parameter logic [N_EVT-1:0] RSVD = evtc_pkg::RSVD_BITS,
  localparam int N_NIB = N_EVT / NIB,
  localparam int SEL_W = (N_NIB > 1) ? $clog2(N_NIB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse_i,
  input  logic             clr_evt_i,
  input  logic [N_EVT-1:0] clr_mask_i,
  input  logic             ien_wr_i,
  input  logic [N_EVT-1:0] ien_data_i,
  input  logic             hen_wr_i,
  input  logic [N_EVT-1:0] hen_data_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             irq_ack_i,
  input  logic             hold_req_i,
  input  logic             reti_i,
  input  logic [SEL_W-1:0] cause_sel_i,
  output logic [N_EVT-1:0] evt_flags_o,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             hold_o,
  output logic [NIB-1:0]   cause_nib_o
);
  logic [N_EVT-1:0] ien_q;
  logic [N_EVT-1:0] hen_q;
  logic [N_EVT-1:0] flags;
  logic [N_EVT-1:0] grant;
  logic [N_EVT-1:0] cause_vec;
  logic [NIB-1:0]   cause_nibs [N_NIB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      hen_q <= '0;
    end else begin
      if (ien_wr_i) ien_q <= ien_data_i;
      if (hen_wr_i) hen_q <= hen_data_i;
    end
  end

  evtc_flag_bank #(.N_EVT(N_EVT), .RSVD(RSVD)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse    (evt_pulse_i),
    .clr_en   (clr_evt_i),
    .clr_mask (clr_mask_i),
    .grant    (grant),
    .flags    (flags)
  );

  evtc_arbiter #(.N_EVT(N_EVT), .VEC_W(VEC_W), .STEP(STEP)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .ien     (ien_q),
    .en_cmd  (gie_set_i || ien_wr_i),
    .dis_cmd (gie_clr_i),
    .ack     (irq_ack_i),
    .req     (irq_req_o),
    .vec     (irq_vec_o),
    .grant   (grant)
  );

  // cause follows the flags and the hold mask, so clears propagate at once
  assign cause_vec = flags & hen_q;

  for (genvar n = 0; n < N_NIB; n++) begin : g_nib
    assign cause_nibs[n] = cause_vec[n*NIB +: NIB];
  end

  assign cause_nib_o = cause_nibs[cause_sel_i];

  evtc_hold_ctrl u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cause_any (cause_vec != '0),
    .irq_req   (irq_req_o),
    .hold_req  (hold_req_i),
    .reti      (reti_i),
    .hold      (hold_o)
  );

  assign evt_flags_o = flags;
endmodule

// File: rtl/evtc_checker.sv
module evtc_checker #(
  parameter int N_EVT = evtc_pkg::EVT_N,
  parameter logic [N_EVT-1:0] RSVD = evtc_pkg::RSVD_BITS
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_pulse_i,
  input logic             irq_ack_i,
  input logic             gie_set_i,
  input logic             ien_wr_i,
  input logic [N_EVT-1:0] evt_flags_o,
  input logic             irq_req_o,
  input logic             hold_o,
  input logic [N_EVT-1:0] cause
);
  AST_RSVD_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flags_o & RSVD) == '0); // R1

  AST_PULSE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_pulse_i & ~RSVD) != '0) |=>
      ((evt_flags_o & $past(evt_pulse_i & ~RSVD)) == $past(evt_pulse_i & ~RSVD))); // R2

  AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (evt_flags_o != '0)); // R3

  AST_ACCEPT_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_ack_i && !gie_set_i && !ien_wr_i) |=> !irq_req_o); // R4

  AST_CAUSE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (cause & ~evt_flags_o) == '0); // R6

  AST_CAUSE_BLOCKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != '0) |=> !hold_o); // R7

  AST_IRQ_LEAVES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && irq_req_o) |=> !hold_o); // R8
endmodule

bind evt_irq_ctrl evtc_checker u_evtc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_pulse_i (evt_pulse_i),
  .irq_ack_i   (irq_ack_i),
  .gie_set_i   (gie_set_i),
  .ien_wr_i    (ien_wr_i),
  .evt_flags_o (evt_flags_o),
  .irq_req_o   (irq_req_o),
  .hold_o      (hold_o),
  .cause       (cause_vec)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_pulse_i = '0;
  logic        clr_evt_i = 1'b0;
  logic [7:0]  clr_mask_i = '0;
  logic        ien_wr_i = 1'b0;
  logic [7:0]  ien_data_i = '0;
  logic        hen_wr_i = 1'b0;
  logic [7:0]  hen_data_i = '0;
  logic        gie_set_i = 1'b0;
  logic        gie_clr_i = 1'b0;
  logic        irq_ack_i = 1'b0;
  logic        hold_req_i = 1'b0;
  logic        reti_i = 1'b0;
  logic [0:0]  cause_sel_i = '0;
  logic [7:0]  evt_flags_o;
  logic        irq_req_o;
  logic [10:0] irq_vec_o;
  logic        hold_o;
  logic [3:0]  cause_nib_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_irq_ctrl i_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt_pulse_i), .clr_evt_i(clr_evt_i),
    .clr_mask_i(clr_mask_i), .ien_wr_i(ien_wr_i), .ien_data_i(ien_data_i),
    .hen_wr_i(hen_wr_i), .hen_data_i(hen_data_i), .gie_set_i(gie_set_i),
    .gie_clr_i(gie_clr_i), .irq_ack_i(irq_ack_i), .hold_req_i(hold_req_i),
    .reti_i(reti_i), .cause_sel_i(cause_sel_i), .evt_flags_o(evt_flags_o),
    .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .hold_o(hold_o),
    .cause_nib_o(cause_nib_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock edge; strobes go low again 1 ns after it
  task automatic cyc();
    @(posedge clk);
    #1;
    evt_pulse_i = '0; clr_evt_i = 0; ien_wr_i = 0; hen_wr_i = 0;
    gie_set_i = 0; gie_clr_i = 0; irq_ack_i = 0; hold_req_i = 0; reti_i = 0;
  endtask

  task automatic load_flags(logic [7:0] p);
    clr_evt_i = 1; clr_mask_i = 8'hFF; cyc();
    evt_pulse_i = p; cyc();
  endtask

  function automatic int exp_vec(logic [7:0] pend);
    for (int i = 0; i < 8; i++) if (pend[i]) return 4 * (i + 1);
    return -1;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R9 reset state
    chk("R9 flags", evt_flags_o, 0);
    chk("R9 req", irq_req_o, 0);
    chk("R9 hold", hold_o, 0);
    cause_sel_i = 0; #1 chk("R9 cause lo", cause_nib_o, 0);
    cause_sel_i = 1; #1 chk("R9 cause hi", cause_nib_o, 0);
    cause_sel_i = 0;
    evt_pulse_i = 8'h01; cyc();
    chk("R9 ien zero no req", irq_req_o, 0);

    // R1 each source alone
    for (int b = 0; b < 8; b++) begin
      load_flags(8'(1 << b));
      chk("R1 single flag", evt_flags_o, (1 << b) & 8'hF7);
    end

    // R3 every flag pattern, full mask
    ien_wr_i = 1; ien_data_i = 8'hFF; cyc();
    for (int p = 0; p < 256; p++) begin
      load_flags(8'(p));
      chk("R3 req", irq_req_o, int'((p & 8'hF7) != 0));
      if ((p & 8'hF7) != 0) chk("R3 vec", irq_vec_o, exp_vec(8'(p & 8'hF7)));
    end
    // R3 every mask, all flags set
    load_flags(8'hFF);
    for (int m = 0; m < 256; m++) begin
      ien_wr_i = 1; ien_data_i = 8'(m); cyc();
      chk("R3 mask req", irq_req_o, int'((m & 8'hF7) != 0));
      if ((m & 8'hF7) != 0) chk("R3 mask vec", irq_vec_o, exp_vec(8'(m & 8'hF7)));
    end

    // R2 clear by mask, pulse wins
    load_flags(8'hFF);
    clr_evt_i = 1; clr_mask_i = 8'h0F; cyc();
    chk("R2 mask clear", evt_flags_o, 8'hF0);
    clr_evt_i = 1; clr_mask_i = 8'hFF; evt_pulse_i = 8'h21; cyc();
    chk("R2 pulse wins", evt_flags_o, 8'h21);

    // R4 acceptance, R5 re-enable paths
    ien_wr_i = 1; ien_data_i = 8'hFF; cyc();
    load_flags(8'h13);
    chk("R4 vec before", irq_vec_o, 11'h004);
    irq_ack_i = 1; cyc();
    chk("R4 only flag0 cleared", evt_flags_o, 8'h12);
    chk("R4 inhibited", irq_req_o, 0);
    irq_ack_i = 1; cyc();
    chk("R4 ack ignored when inhibited", evt_flags_o, 8'h12);
    gie_set_i = 1; cyc();
    chk("R5 set cmd req", irq_req_o, 1);
    chk("R5 set cmd vec", irq_vec_o, 11'h008);
    gie_clr_i = 1; cyc();
    chk("R5 clr cmd", irq_req_o, 0);
    ien_wr_i = 1; ien_data_i = 8'h10; cyc();
    chk("R5 mask write req", irq_req_o, 1);
    chk("R5 mask write vec", irq_vec_o, 11'h014);

    // R6 cause for every hold mask
    ien_wr_i = 1; ien_data_i = 8'h00; cyc();
    load_flags(8'hFF);
    for (int h = 0; h < 256; h++) begin
      hen_wr_i = 1; hen_data_i = 8'(h); cyc();
      cause_sel_i = 0; #1 chk("R6 cause lo", cause_nib_o, h & 8'h07);
      cause_sel_i = 1; #1 chk("R6 cause hi", cause_nib_o, (h >> 4) & 8'hF);
    end
    clr_evt_i = 1; clr_mask_i = 8'h30; cyc();
    chk("R6 clear drops cause", cause_nib_o, 4'hC);
    hen_wr_i = 1; hen_data_i = 8'h00; cyc();
    chk("R6 zero mask drops cause", cause_nib_o, 0);
    cause_sel_i = 0;

    // R7 hold entry and cause wake
    load_flags(8'h00);
    hold_req_i = 1; cyc();
    chk("R7 enter hold", hold_o, 1);
    hen_wr_i = 1; hen_data_i = 8'h01; evt_pulse_i = 8'h01; cyc();
    chk("R7 hold one more edge", hold_o, 1);
    cyc();
    chk("R7 cause wakes", hold_o, 0);
    hold_req_i = 1; cyc();
    chk("R7 hold refused", hold_o, 0);
    hen_wr_i = 1; hen_data_i = 8'h00; cyc();
    hold_req_i = 1; cyc();
    chk("R7 hold after cause gone", hold_o, 1);

    // R8 interrupt during hold then return
    ien_wr_i = 1; ien_data_i = 8'h02; evt_pulse_i = 8'h02; cyc();
    chk("R8 req in hold", irq_req_o, 1);
    cyc();
    chk("R8 left hold", hold_o, 0);
    irq_ack_i = 1; cyc();
    chk("R8 served flag cleared", evt_flags_o & 8'h02, 0);
    chk("R8 still run", hold_o, 0);
    reti_i = 1; cyc();
    chk("R8 back in hold", hold_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule